// File: doc/BRIEF.md
# Host-to-Local Address Window Remapper

This block translates addresses that a host issues into its firmware space over an LPC-style bus into addresses in the local AHB-style space. Software programs one window through four 32-bit registers on a plain read/write register port. On the host side, each request address arrives with a valid strobe. One cycle later the block returns a registered response: a valid flag, a hit flag and the translated local address.

Translation works on the upper sixteen address bits, so windows are placed at 64 KiB granularity. Two 16-bit masks share one register. The replace mask picks which upper bits are taken from a programmed local base. The keep mask picks which upper bits of the request pass through unchanged. For a window of power-of-two size S, the replace half is the inverse of (S-1) and the keep half is (S>>16)-1, and the window offset is a multiple of S. The same register block also holds a sticky mode bit and a set of event flags that software clears by writing ones.

Top module: `lpc_win_remap`

## Requirements
- R1: After reset, all four registers read as zero, `mode_o` is 0, and `rsp_valid_o` and `rsp_hit_o` are 0.
- R2: The control register at byte offset 0x80 is plain read/write storage for all 32 bits. Bit 8 is enable A and bit 10 is enable B.
- R3: A request can hit only while control bits 8 and 10 are both 1. If either bit is 0, every response has `rsp_hit_o` = 0.
- R4: The window register at 0x88 holds the local base in bits [31:16] and the host base in bits [15:0]. A request hits when, for every bit position i in 0..15 where the keep mask bit is 0, request address bit 16+i equals host base bit i.
- R5: The mask register at 0x8C holds the replace mask in bits [31:16] and the keep mask in bits [15:0]. Translated bit 16+i is local base bit i where replace bit i is 1, else the request bit where keep bit i is 1, else 0.
- R6: Translated address bits [15:0] always equal request address bits [15:0].
- R7: The response is registered. `rsp_valid_o`, `rsp_hit_o` and `rsp_addr_o` reflect the request presented in the previous cycle. A cycle without `req_valid_i` gives `rsp_valid_o` = 0 and `rsp_hit_o` = 0 in the following cycle.
- R8: Bit 17 of the register at 0x84 is the mode bit, driven on `mode_o`. Writing 1 to it sets it. Writing 0 leaves it set. Only reset clears it.
- R9: Every bit of the register at 0x84 other than bit 17 is an event flag. A flag is set by a 1 on the matching `sts_evt_i` bit and cleared by writing 1 to it; writing 0 leaves it unchanged. When an event and a clearing write hit the same bit in the same cycle, the flag stays set. `sts_evt_i` bit 17 has no effect.
- R10: The registers at 0x88 and 0x8C are plain read/write storage for all 32 bits.
- R11: Reads from any offset other than 0x80, 0x84, 0x88 and 0x8C return 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | REG_AW | Register byte offset |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, combinational on `reg_addr_i` |
| sts_evt_i | input | 32 | Event inputs that set the sticky flags at 0x84 |
| mode_o | output | 1 | Mode bit (bit 17 of 0x84) |
| req_valid_i | input | 1 | Host request strobe |
| req_addr_i | input | 32 | Host firmware-space address |
| rsp_valid_o | output | 1 | Response valid, one cycle after the request |
| rsp_hit_o | output | 1 | Request fell inside the enabled window |
| rsp_addr_o | output | 32 | Translated local address |

## Verification
The bench builds the block with its default register offset width of 8 bits. With that width every mapped offset can be reached, and so can neighbouring unmapped offsets such as 0x90, which are used to probe the decode. The random part programs power-of-two windows from 64 KiB up to 256 MiB at random aligned host and local bases. It predicts hits and targets from the window arithmetic (base plus offset), not from the mask rule. Directed cases cover lopsided masks, each enable bit alone, and an event racing a clearing write.

// File: rtl/lpc_win_pkg.sv
package lpc_win_pkg;
  localparam int HW = 16;
  localparam int AW = 2 * HW;
  localparam int DW = 32;

  localparam logic [7:0] OFF_CTL = 8'h80;
  localparam logic [7:0] OFF_STS = 8'h84;
  localparam logic [7:0] OFF_WIN = 8'h88;
  localparam logic [7:0] OFF_MSK = 8'h8C;

  localparam int CTL_EN_A = 8;
  localparam int CTL_EN_B = 10;
  localparam int STS_MODE = 17;

  localparam logic [DW-1:0] MODE_BIT  = DW'(1) << STS_MODE;
  localparam logic [DW-1:0] FLAG_BITS = ~MODE_BIT;

  typedef struct packed {
    logic [HW-1:0] loc_base;
    logic [HW-1:0] host_base;
    logic [HW-1:0] rep_mask;
    logic [HW-1:0] keep_mask;
  } win_cfg_t;
endpackage

// File: rtl/lpc_win_regs.sv
module lpc_win_regs
  import lpc_win_pkg::*;
#(
  parameter int REG_AW = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [REG_AW-1:0] addr_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [DW-1:0]     rdata_o,
  input  logic [DW-1:0]     evt_i,
  output logic              en_o,
  output logic              mode_o,
  output win_cfg_t          cfg_o
);
  logic [DW-1:0] ctl_q, sts_q, win_q, msk_q;
  logic [DW-1:0] sts_d, w1c, w1s;
  logic sel_ctl, sel_sts, sel_win, sel_msk, mapped;

  assign sel_ctl = (addr_i == REG_AW'(OFF_CTL));
  assign sel_sts = (addr_i == REG_AW'(OFF_STS));
  assign sel_win = (addr_i == REG_AW'(OFF_WIN));
  assign sel_msk = (addr_i == REG_AW'(OFF_MSK));
  assign mapped  = sel_ctl | sel_sts | sel_win | sel_msk;

  assign w1c   = (we_i && sel_sts) ? (wdata_i & FLAG_BITS) : '0;
  assign w1s   = (we_i && sel_sts) ? (wdata_i & MODE_BIT) : '0;
  // event wins over a same-cycle clear
  assign sts_d = (sts_q & ~w1c) | (evt_i & FLAG_BITS) | w1s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_q <= '0;
      sts_q <= '0;
      win_q <= '0;
      msk_q <= '0;
    end else begin
      sts_q <= sts_d;
      if (we_i && sel_ctl) ctl_q <= wdata_i;
      if (we_i && sel_win) win_q <= wdata_i;
      if (we_i && sel_msk) msk_q <= wdata_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (sel_ctl) rdata_o = ctl_q;
    if (sel_sts) rdata_o = sts_q;
    if (sel_win) rdata_o = win_q;
    if (sel_msk) rdata_o = msk_q;
  end

  assign en_o   = ctl_q[CTL_EN_A] & ctl_q[CTL_EN_B];
  assign mode_o = sts_q[STS_MODE];
  assign cfg_o  = '{loc_base:  win_q[DW-1:HW], host_base: win_q[HW-1:0],
                    rep_mask:  msk_q[DW-1:HW], keep_mask: msk_q[HW-1:0]};

  // R8
  mode_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sts_q[STS_MODE] |=> sts_q[STS_MODE]);

  // R9
  evt_sets_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((evt_i & FLAG_BITS) != '0) |=>
      ((sts_q & $past(evt_i & FLAG_BITS)) == $past(evt_i & FLAG_BITS)));

  // R11
  unmapped_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !mapped) |=> ($stable(ctl_q) && $stable(win_q) && $stable(msk_q)));
endmodule

// File: rtl/lpc_win_xlat.sv
module lpc_win_xlat
  import lpc_win_pkg::*;
(
  input  logic          en_i,
  input  win_cfg_t      cfg_i,
  input  logic [AW-1:0] addr_i,
  output logic          hit_o,
  output logic [AW-1:0] addr_o
);
  logic [HW-1:0] bit_ok;
  logic [HW-1:0] hi;

  for (genvar i = 0; i < HW; i++) begin : g_bit
    assign bit_ok[i] = cfg_i.keep_mask[i] | (addr_i[HW+i] == cfg_i.host_base[i]);
    // replace has priority over keep; neither gives 0
    assign hi[i] = cfg_i.rep_mask[i]  ? cfg_i.loc_base[i] :
                   cfg_i.keep_mask[i] ? addr_i[HW+i]      : 1'b0;
  end

  assign hit_o  = en_i & (&bit_ok);
  assign addr_o = {hi, addr_i[HW-1:0]};
endmodule

// File: rtl/lpc_win_remap.sv
module lpc_win_remap
  import lpc_win_pkg::*;
#(
  parameter int REG_AW = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [REG_AW-1:0] reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  input  logic [31:0]       sts_evt_i,
  output logic              mode_o,
  input  logic              req_valid_i,
  input  logic [31:0]       req_addr_i,
  output logic              rsp_valid_o,
  output logic              rsp_hit_o,
  output logic [31:0]       rsp_addr_o
);
  logic          en;
  win_cfg_t      cfg;
  logic          x_hit;
  logic [AW-1:0] x_addr;

  lpc_win_regs #(.REG_AW(REG_AW)) i_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (reg_we_i),
    .addr_i  (reg_addr_i),
    .wdata_i (reg_wdata_i),
    .rdata_o (reg_rdata_o),
    .evt_i   (sts_evt_i),
    .en_o    (en),
    .mode_o  (mode_o),
    .cfg_o   (cfg)
  );

  lpc_win_xlat i_xlat (
    .en_i   (en),
    .cfg_i  (cfg),
    .addr_i (req_addr_i),
    .hit_o  (x_hit),
    .addr_o (x_addr)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_hit_o   <= 1'b0;
      rsp_addr_o  <= '0;
    end else begin
      rsp_valid_o <= req_valid_i;
      rsp_hit_o   <= req_valid_i & x_hit;
      if (req_valid_i) rsp_addr_o <= x_addr;
    end
  end

  // R7
  idle_no_hit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> (!rsp_valid_o && !rsp_hit_o));

  // R3
  disabled_no_hit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en |=> !rsp_hit_o);

  // R6
  low_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> (rsp_addr_o[15:0] == $past(req_addr_i[15:0])));
endmodule

// File: tb/test_lpc_win_remap.sv
`timescale 1ns/1ps
module test_lpc_win_remap;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [31:0] sts_evt = '0;
  logic        mode;
  logic        req_valid = 1'b0;
  logic [31:0] req_addr = '0;
  logic        rsp_valid, rsp_hit;
  logic [31:0] rsp_addr;

  int unsigned n_chk = 0, n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  lpc_win_remap #(.REG_AW(8)) i_lpc_win_remap (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_we_i(reg_we), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata),
    .reg_rdata_o(reg_rdata), .sts_evt_i(sts_evt), .mode_o(mode),
    .req_valid_i(req_valid), .req_addr_i(req_addr),
    .rsp_valid_o(rsp_valid), .rsp_hit_o(rsp_hit), .rsp_addr_o(rsp_addr)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input string tag, input logic [7:0] a, input logic [31:0] exp);
    @(negedge clk);
    reg_addr = a;
    #1;
    chk(tag, reg_rdata, exp);
  endtask

  task automatic evt(input logic [31:0] e);
    @(negedge clk);
    sts_evt = e;
    @(negedge clk);
    sts_evt = '0;
  endtask

  task automatic send(input string tag, input logic [31:0] a,
                      input bit exp_hit, input logic [31:0] exp_addr);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    chk({tag, " valid"}, 32'(rsp_valid), 32'd1);
    chk({tag, " hit"}, 32'(rsp_hit), 32'(exp_hit));
    if (exp_hit) chk({tag, " addr"}, rsp_addr, exp_addr);
    else chk({tag, " low"}, 32'(rsp_addr[15:0]), 32'(a[15:0]));
  endtask

  function automatic logic [31:0] win_mask(input int k);
    logic [31:0] s = 32'd1 << k;
    return ~(s - 1) | ((s >> 16) - 1);
  endfunction

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    #20 rst_n = 1'b1;

    // R1 reset state
    rd("R1 ctl", 8'h80, 0); rd("R1 sts", 8'h84, 0);
    rd("R1 win", 8'h88, 0); rd("R1 msk", 8'h8C, 0);
    chk("R1 mode", 32'(mode), 0);
    chk("R1 rsp", {30'd0, rsp_valid, rsp_hit}, 0);

    // R2 / R10 readback
    wr(8'h80, 32'hFFFF_FFFF); rd("R2 ctl", 8'h80, 32'hFFFF_FFFF);
    wr(8'h88, 32'hDEAD_BEEF); rd("R10 win", 8'h88, 32'hDEAD_BEEF);
    wr(8'h8C, 32'h1234_5678); rd("R10 msk", 8'h8C, 32'h1234_5678);

    // R11 unmapped
    wr(8'h90, 32'hA5A5_A5A5); rd("R11 rd90", 8'h90, 0);
    wr(8'h81, 32'h0); rd("R11 ctl kept", 8'h80, 32'hFFFF_FFFF);
    rd("R11 win kept", 8'h88, 32'hDEAD_BEEF);

    // R9 events, bit 17 event ignored
    evt(32'h0002_0005);
    rd("R9 set", 8'h84, 32'h0000_0005);
    chk("R9 evt17 ignored", 32'(mode), 0);
    wr(8'h84, 32'h0000_0001); rd("R9 w1c", 8'h84, 32'h0000_0004);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 8'h84; reg_wdata = 32'h4; sts_evt = 32'h4;
    @(negedge clk);
    reg_we = 1'b0; sts_evt = '0;
    rd("R9 evt beats clear", 8'h84, 32'h0000_0004);

    // R8 mode set, not cleared by 0, flags untouched by lone bit 17
    wr(8'h84, 32'h0002_0000);
    chk("R8 mode set", 32'(mode), 1);
    rd("R8 flags kept", 8'h84, 32'h0002_0004);
    wr(8'h84, 32'h0000_0000);
    rd("R8 mode stays", 8'h84, 32'h0002_0004);

    // 64 KiB window host 0x0012xxxx -> local 0xABCDxxxx
    wr(8'h88, 32'hABCD_0012); wr(8'h8C, win_mask(16));
    wr(8'h80, 32'h0000_0100); send("R3 only A", 32'h0012_BEEF, 0, 0);
    wr(8'h80, 32'h0000_0400); send("R3 only B", 32'h0012_BEEF, 0, 0);
    wr(8'h80, 32'h0000_0500); send("R6 lowpass", 32'h0012_BEEF, 1, 32'hABCD_BEEF);
    send("R4 miss", 32'h0013_BEEF, 0, 0);

    // R7 idle cycle
    @(negedge clk);
    @(negedge clk);
    chk("R7 idle", {30'd0, rsp_valid, rsp_hit}, 0);

    // R5 lopsided masks: replace FF00, keep 00F0, nibble 000F neither
    wr(8'h88, 32'hAB00_1203); wr(8'h8C, 32'hFF00_00F0);
    send("R5 custom", 32'h1233_5555, 1, 32'hAB30_5555);
    send("R4 custom miss", 32'h1303_5555, 0, 0);

    // random power-of-two windows
    for (int blk = 0; blk < 40; blk++) begin
      int k = 16 + int'($urandom % 13);
      logic [31:0] s = 32'd1 << k;
      logic [31:0] hb = $urandom & ~(s - 1);
      logic [31:0] lb = $urandom & ~(s - 1);
      logic [31:0] c = $urandom;
      bit en;
      if (($urandom % 4) != 0) c = c | 32'h500;
      en = c[8] & c[10];
      wr(8'h88, {lb[31:16], hb[31:16]});
      wr(8'h8C, win_mask(k));
      wr(8'h80, c);
      for (int j = 0; j < 12; j++) begin
        logic [31:0] a = ($urandom % 2) ? (hb | ($urandom & (s - 1))) : $urandom;
        bit h = en && (((a ^ hb) & ~(s - 1)) == 0);
        send(h ? "R4 R5 rand hit" : "R3 R4 rand miss", a, h, lb | (a & (s - 1)));
      end
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule